// File: doc/BRIEF.md
# Condition Flag and Branch Unit

This unit keeps the zero and negative condition bits of a 16-bit load/store processor and turns each branch instruction into the next program counter. Arithmetic and logic instructions deliver their result together with a flag-update strobe. On the next clock edge the unit records whether that result was zero and copies its sign bit. A branch-execute strobe marks the cycle in which the current instruction is a branch candidate. In that cycle the unit reads the 5-bit opcode in the top bits of the instruction, tests the stored flags, and selects between the sequential address and a PC-relative target.

Branch selection is purely combinational from the current PC, the instruction and the registered flags. A branch that arrives in the same cycle as a flag update therefore sees the flags as they were before that update. The displacement is a signed 11-bit word count, doubled to form a byte distance, so instructions stay on even addresses. All address sums wrap modulo 2^16.

Top module: `cond_branch_unit`

## Requirements
- R1: On a rising clock edge with `flag_we_i` high, Z becomes 1 exactly when `alu_result_i` is all zeros, and N becomes `alu_result_i[15]`.
- R2: Reset clears Z and N to 0, and both hold their values on every edge where `flag_we_i` is low, whatever `alu_result_i` carries.
- R3: The opcode field is `instr_i[15:11]`. Opcode 5'b11000 (always) is taken whenever `branch_exec_i` is high.
- R4: Opcode 5'b11001 is taken when Z=1, and opcode 5'b11010 is taken when Z=0.
- R5: Opcode 5'b11011 is taken when N=1, and opcode 5'b11110 is taken when N=0.
- R6: Opcode 5'b11100 is taken when N=1 or Z=1, and opcode 5'b11101 is taken when N=0 and Z=0.
- R7: Opcode 5'b11111 and every opcode below 5'b11000 are never taken.
- R8: With `branch_exec_i` low, `taken_o` is 0 and `next_pc_o` is `pc_i`+2 for any instruction.
- R9: When taken, `next_pc_o` equals `pc_i` plus twice the two's-complement value of `instr_i[10:0]`, modulo 2^16.
- R10: When not taken, `next_pc_o` equals `pc_i`+2 modulo 2^16.
- R11: A branch evaluated in the same cycle as a flag update uses the flags from before that update. The new flags apply from the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_i | input | 16 | Byte address of the current instruction |
| instr_i | input | 16 | Current instruction word |
| alu_result_i | input | 16 | Result of the current data-manipulation instruction |
| flag_we_i | input | 1 | Load Z and N from `alu_result_i` at the next edge |
| branch_exec_i | input | 1 | Current instruction may redirect the PC |
| next_pc_o | output | 16 | Address of the next instruction |
| taken_o | output | 1 | High when the branch target is selected |

## Verification
Each branch opcode is driven against flag states built from three results: zero, a positive value and a value with bit 15 set. This separates conditions that differ only in whether they read Z, N or both. Displacements of +1, -1, the largest positive and the most negative value, together with PCs near 0xFFFF, show whether the offset is sign-extended and doubled and whether the sum wraps. Directed sequences check that a branch without the execute strobe has no effect and that the flags survive idle cycles with changing results. They also check that the post-reset flag state decides the first branches and that an update in the branch's own cycle is not yet visible.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

  localparam int OPC_W = 5;

  typedef enum logic [OPC_W-1:0] {
    OP_JMP_ALWAYS = 5'b11000,
    OP_JMP_ZERO   = 5'b11001,
    OP_JMP_NZERO  = 5'b11010,
    OP_JMP_NEG    = 5'b11011,
    OP_JMP_NPOS   = 5'b11100,
    OP_JMP_POS    = 5'b11101,
    OP_JMP_NNEG   = 5'b11110,
    OP_RESERVED   = 5'b11111
  } br_op_e;

  typedef struct packed {
    logic z;
    logic n;
  } flags_t;

  // Condition test for one opcode against the stored flags.
  function automatic logic cond_holds(logic [OPC_W-1:0] opc, flags_t f);
    logic ok;
    case (br_op_e'(opc))
      OP_JMP_ALWAYS: ok = 1'b1;
      OP_JMP_ZERO:   ok = f.z;
      OP_JMP_NZERO:  ok = !f.z;
      OP_JMP_NEG:    ok = f.n;
      OP_JMP_NPOS:   ok = f.n | f.z;
      OP_JMP_POS:    ok = !f.n & !f.z;
      OP_JMP_NNEG:   ok = !f.n;
      default:       ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/cbu_flag_reg.sv
module cbu_flag_reg
  import cbu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] result_i,
  output flags_t            flags_o
);

  function automatic flags_t derive_flags(logic [DATA_W-1:0] r);
    flags_t f;
    f.z = (r == '0);
    f.n = r[DATA_W-1];
    return f;
  endfunction

  flags_t flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (load_i) begin
      flags_q <= derive_flags(result_i);
    end
  end

  assign flags_o = flags_q;

endmodule

// File: rtl/cbu_cond_eval.sv
module cbu_cond_eval
  import cbu_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  input  flags_t           flags_i,
  input  logic             exec_i,
  output logic             is_branch_o,
  output logic             cond_ok_o,
  output logic             taken_o
);

  localparam logic [OPC_W-1:0] FIRST_BR = OP_JMP_ALWAYS;
  localparam logic [OPC_W-1:0] LAST_BR  = OP_JMP_NNEG;

  always_comb begin
    is_branch_o = (opc_i >= FIRST_BR) && (opc_i <= LAST_BR);
    cond_ok_o   = cond_holds(opc_i, flags_i);
    taken_o     = exec_i && is_branch_o && cond_ok_o;
  end

endmodule

// File: rtl/cbu_target_calc.sv
module cbu_target_calc #(
  parameter int PC_W  = 16,
  parameter int OFF_W = 11
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic             take_i,
  output logic [PC_W-1:0]  seq_pc_o,
  output logic [PC_W-1:0]  jump_pc_o,
  output logic [PC_W-1:0]  next_pc_o
);

  localparam int EXT_W = PC_W - OFF_W - 1;
  localparam logic [PC_W-1:0] STEP = PC_W'(2);

  // Word displacement to byte distance: sign-extend then shift by one.
  function automatic logic [PC_W-1:0] scale_offset(logic [OFF_W-1:0] off);
    return {{EXT_W{off[OFF_W-1]}}, off, 1'b0};
  endfunction

  always_comb begin
    seq_pc_o  = pc_i + STEP;
    jump_pc_o = pc_i + scale_offset(offset_i);
    next_pc_o = take_i ? jump_pc_o : seq_pc_o;
  end

endmodule

// File: rtl/cond_branch_unit.sv
module cond_branch_unit
  import cbu_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PC_W    = 16,
  parameter int INSTR_W = 16,
  parameter int OFF_W   = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PC_W-1:0]    pc_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  alu_result_i,
  input  logic               flag_we_i,
  input  logic               branch_exec_i,
  output logic [PC_W-1:0]    next_pc_o,
  output logic               taken_o
);

  localparam int OPC_LSB = INSTR_W - OPC_W;

  // Named internal events for the bound checker.
  flags_t           flags;
  logic             flag_z;
  logic             flag_n;
  logic [OPC_W-1:0] opcode;
  logic [OFF_W-1:0] offset;
  logic             is_branch;
  logic             cond_ok;
  logic             take;
  logic [PC_W-1:0]  seq_pc;
  logic [PC_W-1:0]  jump_pc;

  assign opcode = instr_i[INSTR_W-1:OPC_LSB];
  assign offset = instr_i[OFF_W-1:0];
  assign flag_z = flags.z;
  assign flag_n = flags.n;

  cbu_flag_reg #(.DATA_W(DATA_W)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (flag_we_i),
    .result_i (alu_result_i),
    .flags_o  (flags)
  );

  cbu_cond_eval u_cond (
    .opc_i       (opcode),
    .flags_i     (flags),
    .exec_i      (branch_exec_i),
    .is_branch_o (is_branch),
    .cond_ok_o   (cond_ok),
    .taken_o     (take)
  );

  cbu_target_calc #(.PC_W(PC_W), .OFF_W(OFF_W)) u_target (
    .pc_i      (pc_i),
    .offset_i  (offset),
    .take_i    (take),
    .seq_pc_o  (seq_pc),
    .jump_pc_o (jump_pc),
    .next_pc_o (next_pc_o)
  );

  assign taken_o = take;

endmodule

// File: rtl/cond_branch_unit_checker.sv
module cond_branch_unit_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] pc_i,
  input logic [15:0] instr_i,
  input logic [15:0] alu_result_i,
  input logic        flag_we_i,
  input logic        branch_exec_i,
  input logic [15:0] next_pc_o,
  input logic        taken_o,
  input logic        flag_z,
  input logic        flag_n
);

  assert_flag_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_i |=> (flag_z == ($past(alu_result_i) == 16'h0000))
                  && (flag_n == $past(alu_result_i[15])));

  assert_flag_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we_i |=> $stable(flag_z) && $stable(flag_n));

  assert_always_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (branch_exec_i && instr_i[15:11] == 5'b11000) |-> taken_o);

  assert_eq_ne_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (branch_exec_i && instr_i[15:12] == 4'b1100 && instr_i[11] == 1'b1)
      |-> (taken_o == flag_z));

  assert_never_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_i[15:11] == 5'b11111 || instr_i[15:14] != 2'b11 || instr_i[13] != 1'b0 && instr_i[15:11] != 5'b11100
       && instr_i[15:11] != 5'b11101 && instr_i[15:11] != 5'b11110) |-> !taken_o);

  assert_no_exec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !branch_exec_i |-> !taken_o);

  assert_fallthrough_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !taken_o |-> next_pc_o == pc_i + 16'd2);

  assert_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> next_pc_o == pc_i + {{4{instr_i[10]}}, instr_i[10:0], 1'b0});

endmodule

bind cond_branch_unit cond_branch_unit_checker u_checker (.*);

// File: tb/cond_branch_unit_bench.sv
module cond_branch_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pc_i = '0;
  logic [15:0] instr_i = '0;
  logic [15:0] alu_result_i = '0;
  logic        flag_we_i = 1'b0;
  logic        branch_exec_i = 1'b0;
  logic [15:0] next_pc_o;
  logic        taken_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cond_branch_unit u_cond_branch_unit (
    .clk           (clk),
    .rst_n         (rst_n),
    .pc_i          (pc_i),
    .instr_i       (instr_i),
    .alu_result_i  (alu_result_i),
    .flag_we_i     (flag_we_i),
    .branch_exec_i (branch_exec_i),
    .next_pc_o     (next_pc_o),
    .taken_o       (taken_o)
  );

  // Entry: {result that sets flags, opcode, offset, pc, expected taken}
  localparam int NV = 20;
  localparam logic [48:0] VECS [NV] = '{
    {16'h0005, 5'b11000, 11'h010, 16'h0100, 1'b1},
    {16'h0000, 5'b11001, 11'h7FF, 16'h0200, 1'b1},
    {16'h0005, 5'b11001, 11'h004, 16'h0200, 1'b0},
    {16'h0005, 5'b11010, 11'h004, 16'h0300, 1'b1},
    {16'h0000, 5'b11010, 11'h004, 16'h0300, 1'b0},
    {16'h8000, 5'b11011, 11'h400, 16'h1000, 1'b1},
    {16'h0005, 5'b11011, 11'h010, 16'h1000, 1'b0},
    {16'h0000, 5'b11100, 11'h002, 16'h2000, 1'b1},
    {16'h8000, 5'b11100, 11'h002, 16'h2000, 1'b1},
    {16'h0005, 5'b11100, 11'h002, 16'h2000, 1'b0},
    {16'h0005, 5'b11101, 11'h3FF, 16'h3000, 1'b1},
    {16'h0000, 5'b11101, 11'h3FF, 16'h3000, 1'b0},
    {16'h8000, 5'b11101, 11'h3FF, 16'h3000, 1'b0},
    {16'h0000, 5'b11110, 11'h008, 16'h4000, 1'b1},
    {16'hFFFF, 5'b11110, 11'h008, 16'h4000, 1'b0},
    {16'h0005, 5'b11111, 11'h008, 16'h5000, 1'b0},
    {16'h0000, 5'b00100, 11'h008, 16'h5000, 1'b0},
    {16'h8000, 5'b10111, 11'h008, 16'h5000, 1'b0},
    {16'h8000, 5'b11000, 11'h010, 16'hFFF0, 1'b1},
    {16'h0005, 5'b11001, 11'h010, 16'hFFFE, 1'b0}
  };

  function automatic string tag_of(logic [4:0] opc);
    case (opc)
      5'b11000: return "R3";
      5'b11001, 5'b11010: return "R4";
      5'b11011, 5'b11110: return "R5";
      5'b11100, 5'b11101: return "R6";
      default: return "R7";
    endcase
  endfunction

  // Expected address, restated with signed integer arithmetic.
  function automatic logic [15:0] expect_pc(logic [15:0] pc, logic [10:0] off, logic tk);
    int disp;
    int sum;
    disp = (int'(off) >= 1024) ? int'(off) - 2048 : int'(off);
    sum  = tk ? int'(pc) + 2 * disp : int'(pc) + 2;
    return 16'(sum & 32'hFFFF);
  endfunction

  task automatic check_bit(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic check_pc(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%04h expected=%04h", tag, what, act, exp);
    end
  endtask

  task automatic load_flags(logic [15:0] r);
    @(negedge clk);
    branch_exec_i = 1'b0;
    alu_result_i  = r;
    flag_we_i     = 1'b1;
    @(negedge clk);
    flag_we_i     = 1'b0;
    alu_result_i  = 16'h1234;
  endtask

  task automatic apply_branch(logic [4:0] opc, logic [10:0] off, logic [15:0] pc, logic ex);
    instr_i       = {opc, off};
    pc_i          = pc;
    branch_exec_i = ex;
    #1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2: reset values Z=0 N=0 observed through conditions
    apply_branch(5'b11001, 11'h004, 16'h0040, 1'b1);
    check_bit("R2", "reset Z=0 so equal-branch not taken", taken_o, 1'b0);
    apply_branch(5'b11011, 11'h004, 16'h0040, 1'b1);
    check_bit("R2", "reset N=0 so negative-branch not taken", taken_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    apply_branch(5'b11101, 11'h004, 16'h0040, 1'b1);
    check_bit("R2", "after reset Z=0 N=0 so positive-branch taken", taken_o, 1'b1);
    check_pc("R9", "positive-branch target after reset", next_pc_o, 16'h0048);

    // Table walk: R1 flag derivation with every branch class
    for (int i = 0; i < NV; i++) begin
      logic [15:0] res;
      logic [4:0]  opc;
      logic [10:0] off;
      logic [15:0] pc;
      logic        tk;
      {res, opc, off, pc, tk} = VECS[i];
      load_flags(res);
      apply_branch(opc, off, pc, 1'b1);
      check_bit(tag_of(opc), $sformatf("vector %0d taken (R1 flags)", i), taken_o, tk);
      check_pc(tk ? "R9" : "R10", $sformatf("vector %0d next pc", i), next_pc_o,
               expect_pc(pc, off, tk));
    end

    // R8: no execute strobe means no redirect
    load_flags(16'h0000);
    apply_branch(5'b11000, 11'h100, 16'h0600, 1'b0);
    check_bit("R8", "always-branch without strobe", taken_o, 1'b0);
    check_pc("R8", "next pc without strobe", next_pc_o, 16'h0602);
    apply_branch(5'b11001, 11'h100, 16'h0600, 1'b0);
    check_bit("R8", "equal-branch with Z=1 without strobe", taken_o, 1'b0);

    // R2: flags hold while idle results change
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      alu_result_i = 16'h8000 + 16'(k);
    end
    apply_branch(5'b11001, 11'h001, 16'h0700, 1'b1);
    check_bit("R2", "Z held across idle cycles", taken_o, 1'b1);
    apply_branch(5'b11011, 11'h001, 16'h0700, 1'b1);
    check_bit("R2", "N held across idle cycles", taken_o, 1'b0);

    // R11: update in the branch's own cycle is not yet visible
    @(negedge clk);
    alu_result_i = 16'h8005;
    flag_we_i    = 1'b1;
    apply_branch(5'b11001, 11'h003, 16'h0800, 1'b1);
    check_bit("R11", "same-cycle update: old Z=1 used", taken_o, 1'b1);
    @(negedge clk);
    flag_we_i = 1'b0;
    #1;
    check_bit("R11", "next cycle: new Z=0 used", taken_o, 1'b0);
    apply_branch(5'b11011, 11'h003, 16'h0800, 1'b1);
    check_bit("R11", "next cycle: new N=1 used", taken_o, 1'b1);
    check_pc("R9", "target after same-cycle update", next_pc_o, 16'h0806);

    // R10: fall-through wrap at top of memory
    apply_branch(5'b11111, 11'h000, 16'hFFFE, 1'b1);
    check_pc("R10", "fall-through wraps", next_pc_o, 16'h0000);

    branch_exec_i = 1'b0;
    @(negedge clk);
    finish_run();
  end

endmodule